// File: doc/BRIEF.md
# Bi-Mode Branch Direction Predictor

This block guesses whether a conditional branch will be taken. It holds three tables of two-bit saturating counters. A bias table, indexed only by low branch address bits, steers each branch to one of two direction banks. One bank starts leaning taken and the other leaning not-taken. Both banks are indexed by the same address bits XORed with a global outcome history. The steered bank's counter gives the final guess. Branches with a strong bias thus collect in the bank that matches it, so two branches that share an entry there tend to agree.

A lookup is combinational. The front end presents an address and gets back the guess, the bank that was chosen, and both table indices. It keeps these with the branch. When the branch resolves, it returns them with the real outcome on the resolve port. The tables and the history then change at the next clock edge, using the returned indices and not the current history.

Each counter is a four-state machine: CTR_SNT (00), CTR_WNT (01), CTR_WT (10), CTR_ST (11). A taken outcome moves it one state up and stops at CTR_ST. A not-taken outcome moves it one state down and stops at CTR_SNT. Every resolve is sorted into one of three update kinds. UPD_NONE applies when no resolve is valid. UPD_DIR_ONLY applies when the bias table chose against the outcome but the chosen bank still guessed right. UPD_BOTH covers every other valid resolve.

Top module: `bimode_predictor`

## Requirements
- R1: After reset every bias counter is 01, every taken-bank counter is 10, every not-taken-bank counter is 01 and the history is all zeros. A lookup then returns bank select 0, guess 0, and a direction index equal to the address field.
- R2: The bias index is lk_addr[IDX_LSB +: CHOICE_W]. The direction index is lk_addr[IDX_LSB +: DIR_W] XOR the history.
- R3: lk_bank_sel is the high bit of the addressed bias counter, where 1 means the taken bank. lk_taken is the high bit of the chosen bank's counter at the direction index.
- R4: Counters saturate. Taken moves a counter up by one and stops at 11. Not-taken moves it down by one and stops at 00.
- R5: On a resolve, only the bank named by up_bank_sel (1 for taken, 0 for not-taken) is updated, at up_dir_idx. The other bank is unchanged.
- R6: The bias counter at up_choice_idx moves toward up_outcome. It is left unchanged when up_bank_sel differs from up_outcome while up_pred_taken equals up_outcome.
- R7: Each valid resolve shifts the history left by one and puts up_outcome in bit 0.
- R8: With up_valid low, no table entry and no history bit changes.
- R9: A resolve writes at the indices carried on the port, whatever the current history holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| lk_addr | input | ADDR_W | Branch address to look up |
| lk_taken | output | 1 | Guessed direction (1 means taken) |
| lk_bank_sel | output | 1 | Bank chosen by the bias table |
| lk_choice_idx | output | CHOICE_W | Bias-table index to save for the resolve |
| lk_dir_idx | output | DIR_W | Direction index to save for the resolve |
| up_valid | input | 1 | Resolve strobe |
| up_choice_idx | input | CHOICE_W | Saved bias index |
| up_dir_idx | input | DIR_W | Saved direction index |
| up_bank_sel | input | 1 | Saved bank choice |
| up_pred_taken | input | 1 | Saved final guess |
| up_outcome | input | 1 | Actual direction (1 means taken) |

## Verification
Directed lookups right after reset check the initial bank biases and the plain address indexing. Directed resolves then separate the bias-kept case (wrong bias, right bank) from the normal bias update. They also saturate one counter at both ends, and they confirm that idle cycles leave both lookups and history unchanged. A seeded random stream, mostly biased by address, feeds back the saved lookup fields. Some of it corrupts the indices or drops the strobe. A bench model predicts every lookup, so a write to the wrong bank, to the wrong index, or at the current history shows up as a mismatched guess or index.

// File: rtl/bimode_pkg.sv
package bimode_pkg;

    typedef enum logic [1:0] {
        CTR_SNT = 2'b00,
        CTR_WNT = 2'b01,
        CTR_WT  = 2'b10,
        CTR_ST  = 2'b11
    } ctr_t;

    typedef enum logic [1:0] {
        UPD_NONE     = 2'b00,
        UPD_DIR_ONLY = 2'b01,
        UPD_BOTH     = 2'b10
    } upd_kind_t;

    function automatic ctr_t ctr_next(ctr_t cur, logic taken);
        ctr_t nxt;
        unique case (cur)
            CTR_SNT: nxt = taken ? CTR_WNT : CTR_SNT;
            CTR_WNT: nxt = taken ? CTR_WT  : CTR_SNT;
            CTR_WT:  nxt = taken ? CTR_ST  : CTR_WNT;
            CTR_ST:  nxt = taken ? CTR_ST  : CTR_WT;
            default: nxt = CTR_WNT;
        endcase
        return nxt;
    endfunction

endpackage

// File: rtl/bimode_ghist.sv
module bimode_ghist #(
    parameter int W = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         shift_en,
    input  logic         shift_bit,
    output logic [W-1:0] hist
);

    logic [W-1:0] hist_q;
    logic [W-1:0] hist_d;

    always_comb begin
        hist_d = shift_en ? {hist_q[W-2:0], shift_bit} : hist_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hist_q <= '0;
        end else begin
            hist_q <= hist_d;
        end
    end

    assign hist = hist_q;

    // R7
    hist_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
        shift_en |=> hist == {$past(hist[W-2:0]), $past(shift_bit)});

    // R8
    hist_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !shift_en |=> $stable(hist));

endmodule

// File: rtl/bimode_ctr_bank.sv
module bimode_ctr_bank
    import bimode_pkg::*;
#(
    parameter int         IDX_W = 6,
    parameter logic [1:0] INIT  = 2'b01
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [1:0]       rd_state,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic             wr_taken
);

    localparam int DEPTH = 1 << IDX_W;

    ctr_t tbl [DEPTH];
    ctr_t wr_cur;
    ctr_t wr_nxt;

    always_comb begin
        wr_cur = tbl[wr_idx];
        wr_nxt = ctr_next(wr_cur, wr_taken);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                tbl[i] <= ctr_t'(INIT);
            end
        end else if (wr_en) begin
            tbl[wr_idx] <= wr_nxt;
        end
    end

    assign rd_state = tbl[rd_idx];

    // R4
    sat_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && wr_taken && wr_cur == CTR_ST |=> tbl[$past(wr_idx)] == CTR_ST);

    // R4
    sat_bot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && !wr_taken && wr_cur == CTR_SNT |=> tbl[$past(wr_idx)] == CTR_SNT);

    // R4
    step_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && wr_taken && wr_cur != CTR_ST
        |=> tbl[$past(wr_idx)] == ctr_t'(2'($past(wr_cur)) + 2'd1));

endmodule

// File: rtl/bimode_predictor.sv
module bimode_predictor
    import bimode_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int IDX_LSB  = 2,
    parameter int CHOICE_W = 6,
    parameter int DIR_W    = 6
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   lk_addr,
    output logic                lk_taken,
    output logic                lk_bank_sel,
    output logic [CHOICE_W-1:0] lk_choice_idx,
    output logic [DIR_W-1:0]    lk_dir_idx,
    input  logic                up_valid,
    input  logic [CHOICE_W-1:0] up_choice_idx,
    input  logic [DIR_W-1:0]    up_dir_idx,
    input  logic                up_bank_sel,
    input  logic                up_pred_taken,
    input  logic                up_outcome
);

    localparam int NBANK = 2;

    logic [DIR_W-1:0] hist;
    logic [1:0]       ch_rd;
    logic [1:0]       dir_rd [NBANK];
    logic [NBANK-1:0] dir_we;
    logic             ch_we;
    upd_kind_t        upd_kind;

    // lookup indexing
    assign lk_choice_idx = lk_addr[IDX_LSB +: CHOICE_W];
    assign lk_dir_idx    = lk_addr[IDX_LSB +: DIR_W] ^ hist;

    // resolve classification
    always_comb begin
        if (!up_valid) begin
            upd_kind = UPD_NONE;
        end else if ((up_bank_sel != up_outcome) && (up_pred_taken == up_outcome)) begin
            upd_kind = UPD_DIR_ONLY;
        end else begin
            upd_kind = UPD_BOTH;
        end
    end

    always_comb begin
        ch_we  = 1'b0;
        dir_we = '0;
        unique case (upd_kind)
            UPD_NONE: begin
                ch_we  = 1'b0;
                dir_we = '0;
            end
            UPD_DIR_ONLY: begin
                ch_we               = 1'b0;
                dir_we[up_bank_sel] = 1'b1;
            end
            UPD_BOTH: begin
                ch_we               = 1'b1;
                dir_we[up_bank_sel] = 1'b1;
            end
            default: begin
                ch_we  = 1'b0;
                dir_we = '0;
            end
        endcase
    end

    bimode_ghist #(.W(DIR_W)) u_hist (
        .clk       (clk),
        .rst_n     (rst_n),
        .shift_en  (up_valid),
        .shift_bit (up_outcome),
        .hist      (hist)
    );

    bimode_ctr_bank #(.IDX_W(CHOICE_W), .INIT(2'b01)) u_choice (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_idx   (lk_choice_idx),
        .rd_state (ch_rd),
        .wr_en    (ch_we),
        .wr_idx   (up_choice_idx),
        .wr_taken (up_outcome)
    );

    // bank 0 leans not-taken, bank 1 leans taken
    for (genvar b = 0; b < NBANK; b++) begin : g_dir
        bimode_ctr_bank #(.IDX_W(DIR_W), .INIT((b == 1) ? 2'b10 : 2'b01)) u_bank (
            .clk      (clk),
            .rst_n    (rst_n),
            .rd_idx   (lk_dir_idx),
            .rd_state (dir_rd[b]),
            .wr_en    (dir_we[b]),
            .wr_idx   (up_dir_idx),
            .wr_taken (up_outcome)
        );
    end

    assign lk_bank_sel = ch_rd[1];
    assign lk_taken    = lk_bank_sel ? dir_rd[1][1] : dir_rd[0][1];

    // R5
    one_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(dir_we));

    // R8
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !up_valid |-> (dir_we == '0) && !ch_we);

endmodule

// File: tb/bimode_predictor_tb.sv
`timescale 1ns/1ps
module bimode_predictor_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] lk_addr = '0;
    logic        lk_taken, lk_bank_sel;
    logic [5:0]  lk_choice_idx, lk_dir_idx;
    logic        up_valid = 1'b0;
    logic [5:0]  up_choice_idx = '0, up_dir_idx = '0;
    logic        up_bank_sel = 1'b0, up_pred_taken = 1'b0, up_outcome = 1'b0;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    logic [1:0] m_ch [64];
    logic [1:0] m_bt [64];
    logic [1:0] m_bn [64];
    logic [5:0] m_hist;

    always #10 clk = ~clk;

    bimode_predictor u_dut (
        .clk(clk), .rst_n(rst_n), .lk_addr(lk_addr),
        .lk_taken(lk_taken), .lk_bank_sel(lk_bank_sel),
        .lk_choice_idx(lk_choice_idx), .lk_dir_idx(lk_dir_idx),
        .up_valid(up_valid), .up_choice_idx(up_choice_idx), .up_dir_idx(up_dir_idx),
        .up_bank_sel(up_bank_sel), .up_pred_taken(up_pred_taken), .up_outcome(up_outcome)
    );

    function automatic logic [1:0] sat(logic [1:0] v, logic t);
        if (t) return (v == 2'b11) ? v : v + 2'd1;
        return (v == 2'b00) ? v : v - 2'd1;
    endfunction

    task automatic check(bit ok, string tag, int act, int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < 64; i++) begin
            m_ch[i] = 2'b01; m_bt[i] = 2'b10; m_bn[i] = 2'b01;
        end
        m_hist = '0;
    endtask

    // lookup at negedge, compare all outputs with the model
    task automatic look(logic [31:0] a, string tag);
        logic [5:0] c, d;
        logic sel, tk;
        @(negedge clk);
        lk_addr = a;
        #2;
        c = a[7:2];
        d = c ^ m_hist;
        sel = m_ch[c][1];
        tk = sel ? m_bt[d][1] : m_bn[d][1];
        check(lk_choice_idx == c && lk_dir_idx == d && lk_bank_sel == sel && lk_taken == tk,
              tag, {lk_choice_idx, lk_dir_idx, lk_bank_sel, lk_taken},
              {c, d, sel, tk});
    endtask

    task automatic resolve(logic v, logic [5:0] c, logic [5:0] d,
                           logic sel, logic pred, logic out);
        @(negedge clk);
        up_valid = v; up_choice_idx = c; up_dir_idx = d;
        up_bank_sel = sel; up_pred_taken = pred; up_outcome = out;
        @(posedge clk);
        #1;
        if (v) begin
            if (sel) m_bt[d] = sat(m_bt[d], out);
            else     m_bn[d] = sat(m_bn[d], out);
            if (!(sel != out && pred == out)) m_ch[c] = sat(m_ch[c], out);
            m_hist = {m_hist[4:0], out};
        end
        up_valid = 1'b0;
    endtask

    initial begin
        #(20 * 150000);
        if (!finished) begin
            bad++; total++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [5:0] h, d;
        logic [31:0] a;
        void'($urandom(32'h5eed_b1d0));
        model_reset();
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state, R2 plain indexing with zero history
        foreach (a_list[i]) begin
            look(a_list[i], "R1");
            check(lk_bank_sel == 1'b0 && lk_taken == 1'b0, "R1 init bias", {lk_bank_sel, lk_taken}, 0);
            check(lk_dir_idx == a_list[i][7:2], "R2 dir idx", lk_dir_idx, a_list[i][7:2]);
        end

        // R6 kept bias: bank 0 chosen, outcome taken, guess right -> UPD_DIR_ONLY
        resolve(1'b1, 6'd12, 6'd13, 1'b0, 1'b1, 1'b1);
        look(32'd12 << 2, "R6 kept");
        check(lk_bank_sel == 1'b0, "R6 bias kept", lk_bank_sel, 0);
        check(lk_taken == 1'b1 && lk_dir_idx == 6'd13, "R5 bank0 write", {lk_dir_idx, lk_taken}, {6'd13, 1'b1});

        // R6 normal bias update: guess wrong -> UPD_BOTH
        resolve(1'b1, 6'd12, 6'd15, 1'b0, 1'b0, 1'b1);
        look(32'd12 << 2, "R6 moved");
        check(lk_bank_sel == 1'b1, "R6 bias moved", lk_bank_sel, 1);

        // R4 saturation at top then bottom on bank 1
        h = m_hist;
        for (int i = 0; i < 5; i++) h = {h[4:0], 1'b1};
        d = 6'd30 ^ h;
        repeat (5) resolve(1'b1, 6'd30, d, 1'b1, 1'b1, 1'b1);
        look(32'd30 << 2, "R4 top");
        check(lk_bank_sel == 1'b1 && lk_taken == 1'b1, "R4 top sat", {lk_bank_sel, lk_taken}, 3);
        repeat (5) resolve(1'b1, 6'd30, d, 1'b1, 1'b1, 1'b0);
        look(32'd30 << 2, "R4 bottom");
        repeat (2) resolve(1'b1, 6'd30, d, 1'b1, 1'b0, 1'b1);
        look(32'd30 << 2, "R4 recover");

        // R7 history visible through direction index of address 0
        h = m_hist;
        resolve(1'b1, 6'd1, 6'd1, 1'b0, 1'b0, 1'b1);
        resolve(1'b1, 6'd1, 6'd1, 1'b0, 1'b0, 1'b0);
        look(32'd0, "R7");
        check(lk_dir_idx == {h[3:0], 2'b10}, "R7 shift", lk_dir_idx, {h[3:0], 2'b10});

        // R8 idle cycles with busy fields
        for (int i = 0; i < 6; i++)
            resolve(1'b0, 6'($urandom), 6'($urandom), 1'($urandom), 1'($urandom), 1'($urandom));
        look(32'd12 << 2, "R8 idle");
        look(32'd30 << 2, "R8 idle");
        look(32'd0, "R8 idle");

        // R9 write at port index differing from current history mapping
        resolve(1'b1, 6'd40, 6'd7, 1'b1, 1'b1, 1'b0);
        look(32'd40 << 2, "R9");

        // random stream, R3 R5 R6 R9 checked through the model
        for (int it = 0; it < 800; it++) begin
            logic [31:0] ra;
            logic v, o, sel, pr;
            logic [5:0] c, dd;
            ra = $urandom;
            look(ra, "R3 random");
            c = lk_choice_idx; dd = lk_dir_idx; sel = lk_bank_sel; pr = lk_taken;
            o = ($urandom % 5 != 0) ? ra[3] ^ ra[9] : 1'($urandom);
            v = ($urandom % 10 != 0);
            if ($urandom % 8 == 0) dd = 6'($urandom);
            if ($urandom % 8 == 0) c = 6'($urandom);
            resolve(v, c, dd, sel, pr, o);
        end

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    logic [31:0] a_list [3] = '{32'h0000_0000, 32'h0000_0044, 32'hffff_fffc};

endmodule